// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command bus of a double-data-rate SDRAM from the device side. On every rising clock edge it samples clock enable, the active-low select and strobe lines, the bank address and the address bus. It turns that sample into a compact command code. It keeps, for each of four banks, whether a row is open and which row that is.

It also holds the two mode registers. It raises a one-cycle error pulse whenever a command breaks the bank protocol: opening a bank that is already open, accessing a bank that is closed, or loading a mode register while rows are still open.

All outputs are registered. The effect of a command sampled at clock edge N is visible on the outputs from edge N onward, and stays there until the next edge. Timing between commands, strobe capture and the data path are not modelled.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A command is accepted only when `cke` is 1 and `csN` is 0 at the rising edge. Otherwise `cmdCode` shows 0 (NOP), no bank or register changes, and `errPulse` stays 0.
- R2: `{rasN,casN,weN}` of an accepted command is decoded to `cmdCode` as follows: 011→1 (activate), 101→2 (read), 100→3 (write), 010→4 (precharge), 001→5 (refresh), 000→6 (register load), 110→7 (burst stop), 111→0 (NOP).
- R3: Activate to a closed bank opens that bank and stores `addr[11:0]` as its row on `bankRow[12*b +: 12]`. The stored row is kept until the next successful activate of that bank.
- R4: Precharge with `addr[10]`=0 closes only bank `bankAddr`. With `addr[10]`=1 it closes every bank. A precharge never raises the error pulse.
- R5: Activate to an open bank raises `errPulse` and leaves that bank's row unchanged.
- R6: Read or write to a closed bank raises `errPulse` and changes no bank state.
- R7: Read or write to an open bank with `addr[10]`=1 closes that bank after the access. With `addr[10]`=0 the bank stays open.
- R8: Register load with all banks closed copies `addr` into `modeReg` when `bankAddr`=0, or into `extModeReg` when `bankAddr`=1. With `bankAddr` 2 or 3 it loads nothing and raises no error.
- R9: Register load while any bank is open raises `errPulse` and loads neither register.
- R10: A load of `modeReg` is refused with `errPulse` unless the latency field `addr[6:4]` is 3, 4 or 5 and the burst field `addr[2:0]` is 1, 2 or 3 (lengths 2, 4, 8). `addr[3]` selects sequential (0) or interleaved (1) ordering and is free.
- R11: After reset all banks are closed, all rows are 0, `cmdCode` is 0, `errPulse` is 0, `modeReg` is 0x032 and `extModeReg` is 0.
- R12: `errPulse` is high only in the cycle after an offending command and returns to 0 after the next clean command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low masks the command |
| csN | input | 1 | Active-low chip select |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe |
| weN | input | 1 | Active-low write enable |
| bankAddr | input | 2 | Bank or register select |
| addr | input | 12 | Row, column/auto-close flag or opcode |
| cmdCode | output | 3 | Registered decoded command |
| bankOpen | output | 4 | One bit per bank, 1 when a row is open |
| bankRow | output | 48 | Row of bank b at bits 12*b+11..12*b |
| modeReg | output | 12 | Mode register contents |
| extModeReg | output | 12 | Extended mode register contents |
| errPulse | output | 1 | One-cycle protocol violation flag |

## Verification
The bench aims at the cases where the bank index and the auto-close flag interact:
- A design that ignored `addr[10]` on precharge would leave other banks open.
- A design that honoured `addr[10]` on activate would corrupt state.
- A second activate to an open bank must not overwrite the stored row. A design that did so would show the new row alongside the error.

It also drives register loads that must be refused: loads with rows open, loads with illegal latency or burst codes, and loads to unused selects. A design that loaded anyway would show a changed `modeReg`. Masked commands, with chip select high or clock enable low, are driven with destructive patterns, so any leak shows up as a closed bank.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MRS  = 3'd6,
    CMD_BST  = 3'd7
  } cmd_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    cmd_e cmd;
    logic openRow;
    logic closeSel;
    logic closeAll;
    logic loadMode;
    logic loadExt;
    logic err;
  } strobe_t;

endpackage

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic                 apFlag,
  input  logic [2:0]           clField,
  input  logic [2:0]           blField,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output strobe_t              stb,
  output logic [NUM_BANKS-1:0] bankHot
);

  cmd_e cmdDec;
  logic selOpen;
  logic anyOpen;
  logic modeOk;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hot
    assign bankHot[b] = (bankAddr == BANK_W'(b));
  end

  assign selOpen = |(bankOpen & bankHot);
  assign anyOpen = |bankOpen;
  assign modeOk  = (clField inside {3'd3, 3'd4, 3'd5}) &&
                   (blField inside {3'd1, 3'd2, 3'd3});

  always_comb begin
    if (!cke || csN) begin
      cmdDec = CMD_NOP;
    end else begin
      case ({rasN, casN, weN})
        3'b011:  cmdDec = CMD_ACT;
        3'b101:  cmdDec = CMD_RD;
        3'b100:  cmdDec = CMD_WR;
        3'b010:  cmdDec = CMD_PRE;
        3'b001:  cmdDec = CMD_REF;
        3'b000:  cmdDec = CMD_MRS;
        3'b110:  cmdDec = CMD_BST;
        default: cmdDec = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.cmd      = cmdDec;
    case (cmdDec)
      CMD_ACT: begin
        if (selOpen) stb.err = 1'b1;
        else         stb.openRow = 1'b1;
      end
      CMD_RD, CMD_WR: begin
        if (!selOpen)    stb.err = 1'b1;
        else if (apFlag) stb.closeSel = 1'b1;
      end
      CMD_PRE: begin
        if (apFlag) stb.closeAll = 1'b1;
        else        stb.closeSel = 1'b1;
      end
      CMD_MRS: begin
        if (anyOpen) begin
          stb.err = 1'b1;
        end else if (bankAddr == BANK_W'(0)) begin
          if (modeOk) stb.loadMode = 1'b1;
          else        stb.err = 1'b1;
        end else if (bankAddr == BANK_W'(1)) begin
          stb.loadExt = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_trk_dp.sv
module sdram_trk_dp
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] MODE_RST = 'h032
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [NUM_BANKS-1:0]       bankHot,
  input  logic [ADDR_W-1:0]          addr,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] bankRow,
  output logic [ADDR_W-1:0]          modeReg,
  output logic [ADDR_W-1:0]          extModeReg,
  output logic [2:0]                 cmdCode,
  output logic                       errPulse
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             openQ;
    logic [ROW_W-1:0] rowQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ <= 1'b0;
        rowQ  <= '0;
      end else if (stb.openRow && bankHot[g]) begin
        openQ <= 1'b1;
        rowQ  <= addr[ROW_W-1:0];
      end else if (stb.closeAll || (stb.closeSel && bankHot[g])) begin
        openQ <= 1'b0;
      end
    end

    assign bankOpen[g]                  = openQ;
    assign bankRow[g*ROW_W +: ROW_W]    = rowQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg    <= MODE_RST;
      extModeReg <= '0;
      cmdCode    <= CMD_NOP;
      errPulse   <= 1'b0;
    end else begin
      if (stb.loadMode) modeReg    <= addr;
      if (stb.loadExt)  extModeReg <= addr;
      cmdCode  <= stb.cmd;
      errPulse <= stb.err;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_RST = 'h032,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cke,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [BANK_W-1:0]          bankAddr,
  input  logic [ADDR_W-1:0]          addr,
  output logic [2:0]                 cmdCode,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] bankRow,
  output logic [ADDR_W-1:0]          modeReg,
  output logic [ADDR_W-1:0]          extModeReg,
  output logic                       errPulse
);

  strobe_t              stb;
  logic [NUM_BANKS-1:0] bankHot;

  sdram_trk_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .bankAddr (bankAddr),
    .apFlag   (addr[AP_BIT]),
    .clField  (addr[6:4]),
    .blField  (addr[2:0]),
    .bankOpen (bankOpen),
    .stb      (stb),
    .bankHot  (bankHot)
  );

  sdram_trk_dp #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .ADDR_W    (ADDR_W),
    .MODE_RST  (MODE_RST)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .bankHot    (bankHot),
    .addr       (addr),
    .bankOpen   (bankOpen),
    .bankRow    (bankRow),
    .modeReg    (modeReg),
    .extModeReg (extModeReg),
    .cmdCode    (cmdCode),
    .errPulse   (errPulse)
  );

endmodule

// File: rtl/sdram_trk_checker.sv
module sdram_trk_checker #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cke,
  input logic                 csN,
  input logic                 rasN,
  input logic                 casN,
  input logic                 weN,
  input logic [BANK_W-1:0]    bankAddr,
  input logic                 apFlag,
  input logic [2:0]           cmdCode,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic [ADDR_W-1:0]    modeReg,
  input logic [ADDR_W-1:0]    extModeReg,
  input logic                 errPulse
);

  logic       taken;
  logic [2:0] pat;
  assign taken = cke && !csN;
  assign pat   = {rasN, casN, weN};

  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !taken |=> (cmdCode == 3'd0) && $stable(bankOpen) && $stable(modeReg)
               && $stable(extModeReg) && !errPulse); // R1

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (taken && pat == 3'b011 && !bankOpen[bankAddr])
      |=> bankOpen[$past(bankAddr)] && !errPulse); // R3

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (taken && pat == 3'b010 && apFlag) |=> (bankOpen == '0) && !errPulse); // R4

  AST_ACT_OPEN_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (taken && pat == 3'b011 && bankOpen[bankAddr]) |=> errPulse); // R5

  AST_ACCESS_CLOSED_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (taken && (pat == 3'b101 || pat == 3'b100) && !bankOpen[bankAddr])
      |=> errPulse && $stable(bankOpen)); // R6

  AST_LOAD_OPEN_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (taken && pat == 3'b000 && (|bankOpen))
      |=> errPulse && $stable(modeReg) && $stable(extModeReg)); // R9

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[6:4] inside {3'd3, 3'd4, 3'd5}) &&
    (modeReg[2:0] inside {3'd1, 3'd2, 3'd3})); // R10

endmodule

bind sdram_cmd_tracker sdram_trk_checker #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cke        (cke),
  .csN        (csN),
  .rasN       (rasN),
  .casN       (casN),
  .weN        (weN),
  .bankAddr   (bankAddr),
  .apFlag     (addr[AP_BIT]),
  .cmdCode    (cmdCode),
  .bankOpen   (bankOpen),
  .modeReg    (modeReg),
  .extModeReg (extModeReg),
  .errPulse   (errPulse)
);

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  bankAddr = '0;
  logic [11:0] addr = '0;
  logic [2:0]  cmdCode;
  logic [3:0]  bankOpen;
  logic [47:0] bankRow;
  logic [11:0] modeReg, extModeReg;
  logic        errPulse;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker u_dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .addr(addr), .cmdCode(cmdCode),
    .bankOpen(bankOpen), .bankRow(bankRow), .modeReg(modeReg),
    .extModeReg(extModeReg), .errPulse(errPulse)
  );

  int nChecks = 0;
  int nFails  = 0;

  // reference state
  bit mOpen [4];
  int mRow  [4];
  int mMode = 'h032;
  int mExt  = 0;
  int mCmd  = 0;
  bit mErr  = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "cmdCode", int'(cmdCode), mCmd);
    chk(tag, "errPulse", int'(errPulse), int'(mErr));
    for (int b = 0; b < 4; b++) begin
      chk(tag, $sformatf("bankOpen[%0d]", b), int'(bankOpen[b]), int'(mOpen[b]));
      chk(tag, $sformatf("bankRow[%0d]", b), int'(bankRow[b*12 +: 12]), mRow[b]);
    end
    chk(tag, "modeReg", int'(modeReg), mMode);
    chk(tag, "extModeReg", int'(extModeReg), mExt);
  endtask

  // behavioural model of one sampled command
  task automatic model(input bit k, input bit cs, input bit r, input bit c,
                       input bit w, input int ba, input int a);
    bit any;
    int cl, bl;
    mErr = 0;
    any = mOpen[0] | mOpen[1] | mOpen[2] | mOpen[3];
    if (!k || cs) mCmd = 0;
    else begin
      case ({r, c, w})
        3'b011: mCmd = 1;
        3'b101: mCmd = 2;
        3'b100: mCmd = 3;
        3'b010: mCmd = 4;
        3'b001: mCmd = 5;
        3'b000: mCmd = 6;
        3'b110: mCmd = 7;
        default: mCmd = 0;
      endcase
    end
    case (mCmd)
      1: if (mOpen[ba]) mErr = 1; else begin mOpen[ba] = 1; mRow[ba] = a & 'hfff; end
      2, 3: if (!mOpen[ba]) mErr = 1; else if (a[10]) mOpen[ba] = 0;
      4: if (a[10]) for (int b = 0; b < 4; b++) mOpen[b] = 0; else mOpen[ba] = 0;
      6: begin
        cl = (a >> 4) & 7;
        bl = a & 7;
        if (any) mErr = 1;
        else if (ba == 0) begin
          if (cl >= 3 && cl <= 5 && bl >= 1 && bl <= 3) mMode = a & 'hfff;
          else mErr = 1;
        end else if (ba == 1) mExt = a & 'hfff;
      end
      default: ;
    endcase
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic issue(input bit k, input bit cs, input bit r, input bit c,
                       input bit w, input int ba, input int a, input string tag);
    cke = k; csN = cs; rasN = r; casN = c; weN = w;
    bankAddr = 2'(ba); addr = 12'(a);
    model(k, cs, r, c, w, ba, a);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic act(input int ba, input int row, input string tag);
    issue(1, 0, 0, 1, 1, ba, row, tag);
  endtask
  task automatic rd(input int ba, input int a, input string tag);
    issue(1, 0, 1, 0, 1, ba, a, tag);
  endtask
  task automatic wr(input int ba, input int a, input string tag);
    issue(1, 0, 1, 0, 0, ba, a, tag);
  endtask
  task automatic pre(input int ba, input int a, input string tag);
    issue(1, 0, 0, 1, 0, ba, a, tag);
  endtask
  task automatic mrs(input int ba, input int a, input string tag);
    issue(1, 0, 0, 0, 0, ba, a, tag);
  endtask
  task automatic nop(input string tag);
    issue(1, 0, 1, 1, 1, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired before the test finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int lfsr;
    for (int b = 0; b < 4; b++) begin mOpen[b] = 0; mRow[b] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll("R11");
    nop("R11");

    // decode of non-bank commands
    issue(1, 0, 0, 0, 1, 0, 0, "R2");   // refresh
    issue(1, 0, 1, 1, 0, 0, 0, "R2");   // burst stop
    nop("R2");

    // open all banks with distinct rows
    act(0, 'hABC, "R3");
    act(1, 'h123, "R3");
    act(2, 'hFFF, "R3");
    act(3, 'h000, "R3");

    // second activate to an open bank
    act(1, 'h555, "R5");
    nop("R12");

    // masked commands must not touch state
    issue(1, 1, 0, 1, 0, 0, 'h400, "R1");  // precharge-all with csN high
    issue(0, 0, 0, 1, 0, 0, 'h400, "R1");  // precharge-all with cke low
    issue(0, 0, 0, 0, 0, 0, 'h043, "R1");  // register load with cke low

    // accesses with and without auto-close
    rd(0, 'h1FF, "R7");
    wr(1, 'h400 | 'h0AA, "R7");
    rd(1, 'h010, "R6");
    wr(1, 'h010, "R6");
    nop("R12");

    // single and all-bank precharge
    pre(2, 'h000, "R4");
    pre(2, 'h000, "R4");
    act(1, 'h777, "R3");
    pre(0, 'h400, "R4");

    // register loads
    act(3, 'h321, "R3");
    mrs(0, 'h043, "R9");
    mrs(1, 'h002, "R9");
    pre(3, 'h000, "R4");
    mrs(0, 'h043, "R8");
    mrs(0, 'h05B, "R8");
    mrs(1, 'h002, "R8");
    mrs(2, 'h7FF, "R8");
    mrs(3, 'h011, "R8");
    mrs(0, 'h022, "R10");
    mrs(0, 'h034, "R10");
    mrs(0, 'h071, "R10");
    mrs(0, 'h031, "R10");
    nop("R12");

    // pseudo-random command stream
    lfsr = 'h1ACE;
    for (int i = 0; i < 400; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
      issue((lfsr & 'h7) != 0, (lfsr >> 3) % 5 == 0, lfsr[4], lfsr[5], lfsr[6],
            (lfsr >> 7) & 3, (lfsr * 7) & 'hFFF, "R2");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule